// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block steers the program counter when an interrupt is taken and when the handler finishes. At each instruction boundary that the core signals, it looks at a vector of pending requests. If the global interrupt enable is set and any request is pending, it picks the request in the lowest bit position. It then stores the 14-bit return address as two bytes on a stack in data memory. That stack grows toward lower addresses. The block clears the global enable, gives a one-cycle acknowledge for the request it serves, and loads the matching vector address into the program counter.

When the core issues a return-from-interrupt command, the block pops the two bytes back, reloads the program counter and sets the global enable again. Entry and return each keep the block busy for four clock cycles. Software can write the global enable while the block is idle, which is how a handler allows nesting. The block owns the stack pointer. The memory port is one byte wide and has a one-cycle read latency.

Top module: `irq_sequencer`

## Requirements
- R1: Request bit i maps to vector i+1, whose program address is 2*(i+1). Vector 0 is kept for reset. When several bits are pending, the lowest-numbered bit is served.
- R2: A request is taken only at a clock edge where all of these hold: the block is idle, `insn_boundary` is 1, `gie` is 1, at least one request bit is set and `reti_cmd` is 0. Otherwise there is no busy cycle, no memory access and the stack pointer does not change.
- R3: When a request is taken, `gie` reads 0 from the next cycle on. `irq_ack` carries a one-hot copy of the served bit for exactly one cycle, which is the first busy cycle.
- R4: Entry writes the low byte pc[7:0] at address `sp`. It then writes the high byte {2'b00, pc[13:8]} at `sp`-1. The stack pointer ends two below its starting value, so it always names the next free byte.
- R5: On entry, `pc_load` is 1 for exactly one cycle, the third busy cycle, with `pc_val` equal to the vector address.
- R6: Entry and return each hold `busy` at 1 for exactly four consecutive cycles.
- R7: On return, each of the two reads first increments the stack pointer and then reads at the new value. The high byte is read first. `pc_load` is 1 in the fourth busy cycle with `pc_val` equal to the popped address. The stack pointer returns to its value before entry, and `gie` reads 1 after the last busy cycle.
- R8: After reset, `gie` is 0, `busy` is 0, `pc_load` is 0 and `sp` equals SP_INIT. While the block is idle, a cycle with `gie_we`=1 loads `gie_wd` into `gie`.
- R9: `reti_cmd` takes precedence over a request in the same cycle. Requests, boundaries and return commands that arrive while `busy` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | N_IRQ | Pending interrupt requests, bit 0 has the highest priority |
| insn_boundary | input | 1 | Strobe that marks an instruction boundary |
| reti_cmd | input | 1 | Return-from-interrupt command |
| gie_we | input | 1 | Write strobe for the global enable |
| gie_wd | input | 1 | Value written to the global enable |
| pc_cur | input | PC_W | Address of the next instruction |
| pc_load | output | 1 | Program counter load strobe |
| pc_val | output | PC_W | Value to load into the program counter |
| gie | output | 1 | Global interrupt enable |
| irq_ack | output | N_IRQ | One-cycle one-hot acknowledge of the served request |
| busy | output | 1 | Entry or return sequence in progress |
| sp | output | SP_W | Stack pointer, next free byte |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | SP_W | Stack memory byte address |
| mem_wdata | output | 8 | Stack memory write data |
| mem_rdata | input | 8 | Stack memory read data, valid one cycle after `mem_re` |

## Verification
The assertions assume several things about the inputs. `mem_rdata` returns the byte addressed one cycle earlier. A return command only arrives when at least one entry is still on the stack. The enable write is never raised in the same cycle as an accepted request. The stimulus respects all of these: it keeps a model of the stack depth and issues a return only when that depth is non-zero. It forces a return when eight entries are outstanding. It writes the enable in its own cycle, with no boundary strobe. The random request patterns cover several requests at once, an empty vector, a missing boundary strobe and a cleared enable, and commands driven into the middle of a busy sequence.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt sequencer.
// Assumes: one encoding of the sequencer state is shared by the control
// logic and its assertions.
package irq_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_VEC,
        ST_SETTLE,
        ST_POP_HI,
        ST_POP_LO,
        ST_CATCH,
        ST_RESUME
    } seq_state_t;
endpackage

// File: rtl/irq_prio_enc.sv
// Fixed-priority selector: the lowest set bit of the request vector wins.
// Assumes: N >= 2; purely combinational.
module irq_prio_enc #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     onehot
);
    // Mask each bit with the absence of all lower bits.
    for (genvar i = 0; i < N; i++) begin : g_mask
        if (i == 0) begin : g_first
            assign onehot[i] = req[i];
        end else begin : g_rest
            assign onehot[i] = req[i] & ~(|req[i-1:0]);
        end
    end

    // Encode the winning position by scanning from the top down.
    always_comb begin
        valid = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Cross-check the two independent selection paths.
    always_comb begin
        if (valid) begin
            // R1
            prio_match_chk: assert (onehot[idx]);
        end
        // R1
        prio_single_chk: assert ($onehot0(onehot));
    end
endmodule

// File: rtl/irq_stack_ptr.sv
// Stack pointer for a stack that grows downward: a push moves it down by
// one, a pop moves it up by one. Assumes push and pop are never raised together.
module irq_stack_ptr #(
    parameter int              SP_W    = 16,
    parameter logic [SP_W-1:0] SP_INIT = 16'h08FF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] sp
);
    // Update the pointer on each push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= SP_INIT;
        else if (push) sp <= sp - 1'b1;
        else if (pop)  sp <= sp + 1'b1;
    end

    // R4
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) - 1'b1);
    // R7
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> sp == $past(sp) + 1'b1);
    // R4
    no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/irq_sequencer.sv
// Interrupt entry and return sequencer.
// Entry: push the return PC (low byte first, at the higher address), clear
// the global enable, acknowledge the request and load the vector.
// Return: pop the high byte, then the low byte, reload the PC and set the
// enable again. Each takes four busy cycles.
// Assumes: 9 <= PC_W <= 16; mem_rdata holds the byte read one cycle after
// mem_re; reti_cmd comes only while the stack holds an entry.
module irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int          N_IRQ   = 8,
    parameter int          PC_W    = 14,
    parameter int          SP_W    = 16,
    parameter int unsigned SP_INIT = 'h08FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             insn_boundary,
    input  logic             reti_cmd,
    input  logic             gie_we,
    input  logic             gie_wd,
    input  logic [PC_W-1:0]  pc_cur,
    output logic             pc_load,
    output logic [PC_W-1:0]  pc_val,
    output logic             gie,
    output logic [N_IRQ-1:0] irq_ack,
    output logic             busy,
    output logic [SP_W-1:0]  sp,
    output logic             mem_we,
    output logic             mem_re,
    output logic [SP_W-1:0]  mem_addr,
    output logic [7:0]       mem_wdata,
    input  logic [7:0]       mem_rdata
);
    localparam int IDX_W = $clog2(N_IRQ);

    seq_state_t       state;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic [N_IRQ-1:0] sel_onehot;
    logic [IDX_W-1:0] idx_q;
    logic [PC_W-1:0]  ret_pc;
    logic [7:0]       hi_q;
    logic [7:0]       lo_q;
    logic             take_irq;
    logic             take_ret;
    logic             push;
    logic             pop;

    irq_prio_enc #(.N(N_IRQ), .IDX_W(IDX_W)) u_prio (
        .req    (irq_req),
        .valid  (sel_valid),
        .idx    (sel_idx),
        .onehot (sel_onehot)
    );

    irq_stack_ptr #(.SP_W(SP_W), .SP_INIT(SP_W'(SP_INIT))) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .sp    (sp)
    );

    // Decide whether a sequence starts this cycle; return wins over entry.
    always_comb begin
        take_ret = (state == ST_IDLE) && reti_cmd;
        take_irq = (state == ST_IDLE) && !reti_cmd && insn_boundary
                   && gie && sel_valid;
    end

    // Step the sequencer through its fixed four-cycle paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:    state <= take_ret ? ST_POP_HI
                                   : (take_irq ? ST_PUSH_LO : ST_IDLE);
                ST_PUSH_LO: state <= ST_PUSH_HI;
                ST_PUSH_HI: state <= ST_VEC;
                ST_VEC:     state <= ST_SETTLE;
                ST_POP_HI:  state <= ST_POP_LO;
                ST_POP_LO:  state <= ST_CATCH;
                ST_CATCH:   state <= ST_RESUME;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Latch the return address and the winning index when entry starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_pc <= '0;
            idx_q  <= '0;
        end else if (take_irq) begin
            ret_pc <= pc_cur;
            idx_q  <= sel_idx;
        end
    end

    // Capture the popped bytes one cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (state == ST_POP_LO) begin
            hi_q <= mem_rdata;
        end else if (state == ST_CATCH) begin
            lo_q <= mem_rdata;
        end
    end

    // Global enable: cleared on entry, set on resume, otherwise writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                gie <= 1'b0;
        else if (take_irq)                         gie <= 1'b0;
        else if (state == ST_RESUME)               gie <= 1'b1;
        else if (gie_we && state == ST_IDLE)       gie <= gie_wd;
    end

    // Drive the stack port, the PC load and the acknowledge.
    always_comb begin
        push      = (state == ST_PUSH_LO) || (state == ST_PUSH_HI);
        pop       = (state == ST_POP_HI) || (state == ST_POP_LO);
        busy      = (state != ST_IDLE);
        mem_we    = push;
        mem_re    = pop;
        mem_addr  = pop ? SP_W'(sp + 1'b1) : sp;
        mem_wdata = (state == ST_PUSH_LO) ? ret_pc[7:0] : 8'(ret_pc >> 8);
        pc_load   = (state == ST_VEC) || (state == ST_RESUME);
        if (state == ST_VEC)
            pc_val = PC_W'((32'(idx_q) + 32'd1) << 1);
        else if (state == ST_RESUME)
            pc_val = PC_W'({hi_q, lo_q});
        else
            pc_val = '0;
        irq_ack   = (state == ST_PUSH_LO) ? (N_IRQ'(1) << idx_q) : '0;
    end

    // R6
    entry_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> busy ##1 busy ##1 busy ##1 busy ##1 !busy);
    // R6
    exit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> busy ##1 busy ##1 busy ##1 busy ##1 !busy);
    // R3
    gie_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !gie);
    // R3
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack) && (irq_ack == '0 || busy));
    // R5
    vec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !pc_load ##1 !pc_load ##1 pc_load);
    // R7
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_ret |=> !pc_load ##1 !pc_load ##1 !pc_load ##1 pc_load ##1 gie);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we && !mem_re && !pc_load);
    // R1
    prio_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> irq_req[sel_idx]);
endmodule

// File: tb/tb_irq_sequencer.sv
module tb_irq_sequencer;
    localparam int N  = 8;
    localparam int PW = 14;
    localparam int SW = 16;
    localparam int SP0 = 'h08FF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          insn_boundary = 1'b0;
    logic          reti_cmd = 1'b0;
    logic          gie_we = 1'b0;
    logic          gie_wd = 1'b0;
    logic [PW-1:0] pc_cur = '0;
    logic          pc_load;
    logic [PW-1:0] pc_val;
    logic          gie;
    logic [N-1:0]  irq_ack;
    logic          busy;
    logic [SW-1:0] sp;
    logic          mem_we;
    logic          mem_re;
    logic [SW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;

    irq_sequencer #(.N_IRQ(N), .PC_W(PW), .SP_W(SW), .SP_INIT(SP0)) dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
        .insn_boundary(insn_boundary), .reti_cmd(reti_cmd),
        .gie_we(gie_we), .gie_wd(gie_wd), .pc_cur(pc_cur),
        .pc_load(pc_load), .pc_val(pc_val), .gie(gie), .irq_ack(irq_ack),
        .busy(busy), .sp(sp), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always #4 clk = ~clk;

    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int        exp_sp;
    bit        exp_gie;
    int        depth;
    int        pcs [0:15];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [N-1:0] r);
        int k = -1;
        for (int i = N - 1; i >= 0; i--) if (r[i]) k = i;
        return k;
    endfunction

    task automatic write_gie(input bit v);
        @(negedge clk);
        gie_we = 1'b1; gie_wd = v;
        @(negedge clk);
        gie_we = 1'b0;
        exp_gie = v;
        chk(gie == v, "R8", "gie after write", int'(gie), int'(v));
    endtask

    // Drive one boundary cycle; poke drives noise while the block is busy.
    task automatic try_irq(input logic [N-1:0] req, input int pc, input bit bnd,
                           input bit poke);
        int  win = lowest(req);
        bit  acc = bnd && exp_gie && (req != 0);
        int  nbusy = 0, nwr = 0, nld = 0, ldk = -1, ldv = 0, nack = 0, ackv = 0;
        int  sp0 = exp_sp;
        @(negedge clk);
        irq_req = req; pc_cur = PW'(pc); insn_boundary = bnd;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) nbusy++;
            if (mem_we) nwr++;
            if (pc_load) begin nld++; ldk = k; ldv = int'(pc_val); end
            if (irq_ack != 0) begin nack++; ackv = int'(irq_ack); end
            irq_req = poke && k == 0 ? 8'hFF : '0;
            insn_boundary = poke && k == 0;
            reti_cmd = poke && k == 1;
            if (k == 0) pc_cur = '0;
        end
        irq_req = '0; insn_boundary = 0; reti_cmd = 0;
        if (acc) begin
            chk(nbusy == 4, "R6", "entry busy cycles", nbusy, 4);
            chk(nld == 1 && ldk == 2, "R5", "vector load cycle", ldk, 2);
            chk(ldv == 2 * (win + 1), "R1", "vector address", ldv, 2 * (win + 1));
            chk(nack == 1 && ackv == (1 << win), "R3", "ack", ackv, 1 << win);
            chk(gie == 0, "R3", "gie after entry", int'(gie), 0);
            chk(int'(mem[sp0[11:0]]) == (pc & 'hFF), "R4", "low byte",
                int'(mem[sp0[11:0]]), pc & 'hFF);
            chk(int'(mem[(sp0 - 1) & 'hFFF]) == ((pc >> 8) & 'h3F), "R4", "high byte",
                int'(mem[(sp0 - 1) & 'hFFF]), (pc >> 8) & 'h3F);
            exp_sp = sp0 - 2;
            exp_gie = 0;
            pcs[depth] = pc & 'h3FFF;
            depth++;
            if (poke) chk(nbusy == 4 && nwr == 2, "R9", "poke during busy", nbusy, 4);
        end else begin
            chk(nbusy == 0 && nwr == 0, "R2", "ignored request", nbusy + nwr, 0);
        end
        chk(int'(sp) == exp_sp, acc ? "R4" : "R2", "sp", int'(sp), exp_sp);
    endtask

    task automatic do_reti(input bit with_req);
        int nbusy = 0, nwr = 0, nld = 0, ldk = -1, ldv = 0, nack = 0;
        @(negedge clk);
        reti_cmd = 1'b1;
        if (with_req) begin irq_req = 8'h01; insn_boundary = 1'b1; end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (busy) nbusy++;
            if (mem_we) nwr++;
            if (pc_load) begin nld++; ldk = k; ldv = int'(pc_val); end
            if (irq_ack != 0) nack++;
            reti_cmd = 0; irq_req = '0; insn_boundary = 0;
        end
        depth--;
        exp_sp = exp_sp + 2;
        exp_gie = 1;
        chk(nbusy == 4, "R6", "return busy cycles", nbusy, 4);
        chk(nld == 1 && ldk == 3, "R7", "resume load cycle", ldk, 3);
        chk(ldv == pcs[depth], "R7", "restored pc", ldv, pcs[depth]);
        chk(int'(sp) == exp_sp, "R7", "sp after return", int'(sp), exp_sp);
        chk(gie == 1, "R7", "gie after return", int'(gie), 1);
        if (with_req) chk(nack == 0 && nwr == 0, "R9", "return wins", nack + nwr, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2917));
        for (int i = 0; i < 4096; i++) mem[i] = 8'hEE;
        exp_sp = SP0; exp_gie = 0; depth = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(gie == 0 && busy == 0 && pc_load == 0, "R8", "reset flags",
            {gie, busy, pc_load}, 0);
        chk(int'(sp) == SP0, "R8", "reset sp", int'(sp), SP0);

        try_irq(8'h04, 'h0200, 1'b1, 1'b0);     // R2: enable clear
        write_gie(1'b1);
        try_irq(8'h04, 'h0200, 1'b0, 1'b0);     // R2: no boundary
        try_irq(8'h00, 'h0200, 1'b1, 1'b0);     // R2: nothing pending
        try_irq(8'h68, 'h0114, 1'b1, 1'b0);     // R1/R4: bit 3 wins
        write_gie(1'b1);
        try_irq(8'h80, 'h3FFF, 1'b1, 1'b1);     // R9: noise while busy
        do_reti(1'b0);
        write_gie(1'b1);
        do_reti(1'b1);                          // R9: return precedence

        for (int it = 0; it < 80; it++) begin
            int r = int'($urandom % 8);
            if (depth >= 8 || (depth > 0 && r < 2)) begin
                do_reti(1'b0);
            end else begin
                if (r == 2) write_gie(1'b0);
                else if (r >= 5) write_gie(1'b1);
                try_irq(N'($urandom), int'($urandom % 'h4000),
                        ($urandom % 4) != 0, 1'b0);
            end
        end
        while (depth > 0) do_reti(1'b0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule